// File: doc/BRIEF.md
# Quantum-Limited Preemptive Bus Arbiter

This block decides which of a small set of bus masters (two by default, up to four) owns a shared bus. Each master raises a request line, and the arbiter answers with a registered one-hot grant. A 32-bit configuration word, held stable by the surrounding logic, sets the scheduling policy. The policy is either fixed priority, using a 2-bit level per master, or uniform round-robin. The word also sets how long an owner may keep the bus before it must give way, whether that tenure is counted in clocks or in completed transfers, which defined-length bursts may be cut short, and which master parks on the bus when nobody asks for it.

The owning master reports its traffic with three inputs. The first pulses when one of its beats completes. The second gives the declared beat count of the burst in progress. The third marks the final beat of that burst. The arbiter hands the bus over only at a transfer boundary. It never splits a burst that the threshold setting protects. When the tenure limit is reached and no other master is waiting, the owner keeps the bus and its quantum count starts again.

Top module: `qbus_arbiter`

## Requirements
- R1: During reset and until the first arbitration, the grant is one-hot on master index 1 (parameter RESET_OWNER), and the round-robin pointer starts at master 0.
- R2: The grant output always has exactly one bit set.
- R3: Bits 9:8 of the configuration word name the parking master by index. A value of N or more selects master 0. When no master requests, this master holds the grant from the next clock edge.
- R4: With bit 0 set to 1 (round-robin), the winner is the first requester at or after the master that follows the most recently granted requester, wrapping from index N-1 to index 0.
- R5: With bit 0 set to 0 (priority), master i has its 2-bit level in bits 12+2i and 13+2i, and a numerically higher level wins. Ties go to the round-robin order of R4. A master at level 00 is still granted when it is the only requester.
- R6: Bits 7:4 hold a code n. For n from 0 to 14, once the owner has used 2^n quanta at a transfer boundary, and another master is requesting, arbitration runs again at that clock edge.
- R7: When the quantum limit is reached and no other master is requesting, the owner keeps the grant and its quantum count restarts from zero.
- R8: Code 15 in bits 7:4 disables preemption. A requesting owner keeps the grant however long it holds it.
- R9: Bit 3 selects the quantum unit. With 0, every clock is one quantum. With 1, only a cycle with beat_done high counts.
- R10: Bits 2:1 select which defined-length bursts (declared length greater than 1) are protected. 00 protects none, 01 protects lengths up to 4, 10 protects lengths up to 8, and 11 protects all. A protected burst keeps the grant until its beat with burst_final completes, even after the quantum limit.
- R11: The grant changes only at an edge where beat_done is high or the owner is not requesting.
- R12: The quantum count restarts on every handover, so each new owner gets a full tenure of 2^n quanta.
- R13: Bits 11:10 and all bits above the last priority field have no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word (mode, burst threshold, quantum unit, quantum code, parking master, priorities) |
| req | input | N_MASTERS | Request line per master |
| beat_done | input | 1 | A beat of the owning master completes this cycle |
| burst_beats | input | LEN_W | Declared beat count of the owner's current burst; 0 or 1 for single or undefined-length transfers |
| burst_final | input | 1 | The completing beat is the last beat of its burst |
| grant | output | N_MASTERS | One-hot grant, registered |

## Verification
Every grant decision is registered, so the grant that answers a set of inputs appears after the first rising edge at which those inputs are present, and after no other edge. The driver applies each cycle's configuration, request and beat inputs at the falling edge and queues the master it expects to own the bus after the following rising edge. The monitor pops that entry 2 ns after the rising edge and compares it with the one-hot grant, which keeps every comparison to the one-edge latency. Tenure and burst checks step one cycle at a time, so a handover that comes one edge early or late shows up as a mismatch on a specific cycle.

// File: rtl/qbus_arb_pkg.sv
package qbus_arb_pkg;

   localparam int CFG_W    = 32;
   localparam int MODE_BIT = 0;
   localparam int BRK_LSB  = 1;
   localparam int UNIT_BIT = 3;
   localparam int CODE_LSB = 4;
   localparam int DFLT_LSB = 8;
   localparam int PRIO_LSB = 12;

   localparam int QCNT_W   = 15;
   localparam logic [3:0] CODE_UNLIMITED = 4'hF;

   localparam int BRK_SHORT = 4;
   localparam int BRK_LONG  = 8;

   typedef enum logic [1:0] {
      BRK_ALL   = 2'b00,
      BRK_OVER4 = 2'b01,
      BRK_OVER8 = 2'b10,
      BRK_NEVER = 2'b11
   } brk_mode_e;

endpackage

// File: rtl/qbus_cfg_decode.sv
module qbus_cfg_decode
   import qbus_arb_pkg::*;
#(
   parameter int N_MASTERS = 2,
   localparam int IW = $clog2(N_MASTERS)
) (
   input  logic [CFG_W-1:0]           cfg_word,
   output logic                       rr_mode,
   output brk_mode_e                  brk,
   output logic                       xfer_unit,
   output logic                       preempt,
   output logic [QCNT_W-1:0]          limit,
   output logic [IW-1:0]              dflt_idx,
   output logic [N_MASTERS-1:0][1:0]  prio
);

   logic [3:0] code;
   logic [1:0] dflt_raw;
   logic       spare_unused;

   assign rr_mode   = cfg_word[MODE_BIT];
   assign brk       = brk_mode_e'(cfg_word[BRK_LSB +: 2]);
   assign xfer_unit = cfg_word[UNIT_BIT];
   assign code      = cfg_word[CODE_LSB +: 4];
   assign dflt_raw  = cfg_word[DFLT_LSB +: 2];

   assign preempt = (code != CODE_UNLIMITED);
   assign limit   = preempt ? (QCNT_W'(1) << code) : '0;

   assign dflt_idx = (int'(dflt_raw) < N_MASTERS) ? IW'(dflt_raw) : '0;

   for (genvar i = 0; i < N_MASTERS; i++) begin : g_prio
      assign prio[i] = cfg_word[PRIO_LSB + 2*i +: 2];
   end

   assign spare_unused = ^{cfg_word[CFG_W-1:PRIO_LSB+2*N_MASTERS],
                           cfg_word[PRIO_LSB-1:DFLT_LSB+2]};

endmodule

// File: rtl/qbus_pick.sv
module qbus_pick #(
   parameter int N_MASTERS = 2,
   localparam int IW = $clog2(N_MASTERS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_MASTERS-1:0]       req,
   input  logic                       rr_mode,
   input  logic [N_MASTERS-1:0][1:0]  prio,
   input  logic [IW-1:0]              ptr,
   output logic                       any_req,
   output logic [IW-1:0]              winner
);

   logic [1:0]           lvl [N_MASTERS];
   logic [1:0]           top_lvl;
   logic [N_MASTERS-1:0] cand;
   logic                 found;

   for (genvar i = 0; i < N_MASTERS; i++) begin : g_lvl
      assign lvl[i]  = rr_mode ? 2'b00 : prio[i];
      assign cand[i] = req[i] && (lvl[i] == top_lvl);
   end

   assign any_req = |req;

   always_comb begin
      top_lvl = 2'b00;
      for (int i = 0; i < N_MASTERS; i++) begin
         if (req[i] && (lvl[i] > top_lvl)) top_lvl = lvl[i];
      end
   end

   always_comb begin
      int idx;
      found  = 1'b0;
      winner = '0;
      for (int k = 0; k < N_MASTERS; k++) begin
         idx = int'(ptr) + k;
         if (idx >= N_MASTERS) idx = idx - N_MASTERS;
         if (!found && cand[idx]) begin
            winner = IW'(idx);
            found  = 1'b1;
         end
      end
   end

   // R4
   winner_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |-> req[winner]);

   for (genvar i = 0; i < N_MASTERS; i++) begin : g_ord
      // R5
      prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req[i] |-> (lvl[winner] >= lvl[i]));
   end

endmodule

// File: rtl/qbus_quantum.sv
module qbus_quantum
   import qbus_arb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              preempt,
   input  logic [QCNT_W-1:0] limit,
   input  logic              restart,
   input  logic              others_req,
   output logic              expired
);

   logic [QCNT_W-1:0] cnt_q;
   logic [QCNT_W:0]   q_next;

   assign q_next  = {1'b0, cnt_q} + {{QCNT_W{1'b0}}, tick};
   assign expired = preempt && (q_next >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !preempt) begin
         cnt_q <= '0;
      end else if (expired) begin
         cnt_q <= others_req ? limit : '0;
      end else begin
         cnt_q <= q_next[QCNT_W-1:0];
      end
   end

   // R12
   handover_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/qbus_burst_guard.sv
module qbus_burst_guard
   import qbus_arb_pkg::*;
#(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             own_req,
   input  logic             beat_done,
   input  logic [LEN_W-1:0] burst_beats,
   input  logic             burst_final,
   input  brk_mode_e        brk,
   output logic             switch_ok
);

   logic defined_len;
   logic protect;
   logic lock_q;
   logic lock_next;

   assign defined_len = (burst_beats > LEN_W'(1));

   always_comb begin
      unique case (brk)
         BRK_ALL:   protect = 1'b0;
         BRK_OVER4: protect = defined_len && (burst_beats <= LEN_W'(BRK_SHORT));
         BRK_OVER8: protect = defined_len && (burst_beats <= LEN_W'(BRK_LONG));
         BRK_NEVER: protect = defined_len;
         default:   protect = 1'b0;
      endcase
   end

   always_comb begin
      if (!own_req)       lock_next = 1'b0;
      else if (beat_done) lock_next = protect && !burst_final;
      else                lock_next = lock_q;
   end

   assign switch_ok = !lock_next && (beat_done || !own_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= lock_next;
   end

   // R10
   burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && own_req && !(beat_done && burst_final)) |-> !switch_ok);

endmodule

// File: rtl/qbus_arbiter.sv
module qbus_arbiter
   import qbus_arb_pkg::*;
#(
   parameter int N_MASTERS   = 2,
   parameter int LEN_W       = 5,
   parameter int RESET_OWNER = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [31:0]          cfg_word,
   input  logic [N_MASTERS-1:0] req,
   input  logic                 beat_done,
   input  logic [LEN_W-1:0]     burst_beats,
   input  logic                 burst_final,
   output logic [N_MASTERS-1:0] grant
);

   localparam int IW = $clog2(N_MASTERS);

   if (N_MASTERS < 2 || N_MASTERS > 4) begin : g_bad_n
      $error("qbus_arbiter: N_MASTERS must lie in 2..4");
   end
   if (LEN_W < 4) begin : g_bad_len
      $error("qbus_arbiter: LEN_W must hold a length of 8");
   end
   if (RESET_OWNER < 0 || RESET_OWNER >= N_MASTERS) begin : g_bad_rst
      $error("qbus_arbiter: RESET_OWNER out of range");
   end

   logic                       rr_mode;
   brk_mode_e                  brk;
   logic                       xfer_unit;
   logic                       preempt;
   logic [QCNT_W-1:0]          limit;
   logic [IW-1:0]              dflt_idx;
   logic [N_MASTERS-1:0][1:0]  prio;

   logic [IW-1:0]              owner_q;
   logic [IW-1:0]              ptr_q;
   logic [N_MASTERS-1:0]       dflt_hot;
   logic                       own_req;
   logic                       others_req;
   logic                       any_req;
   logic [IW-1:0]              winner;
   logic                       switch_ok;
   logic                       expired;
   logic                       rearb;
   logic                       tick;

   qbus_cfg_decode #(.N_MASTERS(N_MASTERS)) u_dec (
      .cfg_word  (cfg_word),
      .rr_mode   (rr_mode),
      .brk       (brk),
      .xfer_unit (xfer_unit),
      .preempt   (preempt),
      .limit     (limit),
      .dflt_idx  (dflt_idx),
      .prio      (prio)
   );

   for (genvar i = 0; i < N_MASTERS; i++) begin : g_hot
      assign grant[i]    = (owner_q  == IW'(i));
      assign dflt_hot[i] = (dflt_idx == IW'(i));
   end

   assign own_req    = |(req & grant);
   assign others_req = |(req & ~grant);
   assign tick       = xfer_unit ? beat_done : 1'b1;

   qbus_pick #(.N_MASTERS(N_MASTERS)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .rr_mode (rr_mode),
      .prio    (prio),
      .ptr     (ptr_q),
      .any_req (any_req),
      .winner  (winner)
   );

   qbus_burst_guard #(.LEN_W(LEN_W)) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .own_req     (own_req),
      .beat_done   (beat_done),
      .burst_beats (burst_beats),
      .burst_final (burst_final),
      .brk         (brk),
      .switch_ok   (switch_ok)
   );

   qbus_quantum u_quant (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .preempt    (preempt),
      .limit      (limit),
      .restart    (rearb),
      .others_req (others_req),
      .expired    (expired)
   );

   assign rearb = switch_ok && (!own_req || (expired && others_req));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= IW'(RESET_OWNER);
         ptr_q   <= '0;
      end else if (rearb) begin
         if (any_req) begin
            owner_q <= winner;
            ptr_q   <= (winner == IW'(N_MASTERS-1)) ? '0 : winner + 1'b1;
         end else begin
            owner_q <= dflt_idx;
         end
      end
   end

   // R2
   onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant) == 1);

   // R11
   boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_done && own_req) |=> $stable(grant));

   // R3
   idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> (grant == $past(dflt_hot)));

endmodule

// File: tb/qbus_arbiter_test.sv
module qbus_arbiter_test;

   localparam int NM = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   cfg_word = 32'h0000_0145;
   logic [NM-1:0] req = '0;
   logic          beat_done = 1'b0;
   logic [4:0]    burst_beats = '0;
   logic          burst_final = 1'b0;
   logic [NM-1:0] grant;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int    exp_q [$];
   string tag_q [$];

   always #5 clk = ~clk;

   qbus_arbiter #(.N_MASTERS(NM), .LEN_W(5), .RESET_OWNER(1)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_word    (cfg_word),
      .req         (req),
      .beat_done   (beat_done),
      .burst_beats (burst_beats),
      .burst_final (burst_final),
      .grant       (grant)
   );

   task automatic step(input logic [31:0] c, input logic [NM-1:0] r,
                       input logic bd, input logic [4:0] len, input logic fin,
                       input int exp_idx, input string tag);
      @(negedge clk);
      cfg_word    = c;
      req         = r;
      beat_done   = bd;
      burst_beats = len;
      burst_final = fin;
      exp_q.push_back(exp_idx);
      tag_q.push_back(tag);
   endtask

   // monitor: pops one expectation per rising edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         int    e;
         string t;
         logic [NM-1:0] want;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         want = NM'(1) << e;
         checks++;
         if (grant !== want) begin
            fails++;
            $display("FAIL %s grant=%b expected=%b", t, grant, want);
         end
         checks++;
         if ($countones(grant) != 1) begin
            fails++;
            $display("FAIL R2 grant=%b expected one-hot", grant);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (grant !== 3'b010) begin
         fails++;
         $display("FAIL R1 reset grant=%b expected=010", grant);
      end
      rst_n = 1'b1;

      // R3: parking master from bits 9:8, out-of-range index -> master 0
      step(32'h0000_0245, 3'b000, 0, 0, 0, 2, "R3 park idx2");
      step(32'h0000_0245, 3'b000, 0, 0, 0, 2, "R3 park hold");
      step(32'h0000_0345, 3'b000, 0, 0, 0, 0, "R3 park range");

      // R4: round-robin, non-preemptive
      step(32'h0000_01F5, 3'b111, 1, 0, 0, 0, "R4 owner keeps");
      step(32'h0000_01F5, 3'b110, 1, 0, 0, 1, "R4 rr 1");
      step(32'h0000_01F5, 3'b111, 1, 0, 0, 1, "R4 rr hold");
      step(32'h0000_01F5, 3'b101, 1, 0, 0, 2, "R4 rr 2");
      step(32'h0000_01F5, 3'b011, 1, 0, 0, 0, "R4 rr wrap 0");
      step(32'h0000_01F5, 3'b110, 1, 0, 0, 1, "R4 rr 1 again");

      // R6 / R12: limit 2 clocks, full tenure for each new owner
      step(32'h0000_0115, 3'b111, 1, 0, 0, 1, "R6 tenure c1");
      step(32'h0000_0115, 3'b111, 1, 0, 0, 2, "R6 preempt to 2");
      step(32'h0000_0115, 3'b111, 1, 0, 0, 2, "R12 new owner full tenure");
      step(32'h0000_0115, 3'b111, 1, 0, 0, 0, "R6 preempt to 0");
      step(32'h0000_0115, 3'b111, 1, 0, 0, 0, "R12 hold");
      step(32'h0000_0115, 3'b111, 1, 0, 0, 1, "R6 preempt to 1");
      step(32'h0000_0115, 3'b111, 1, 0, 0, 1, "R12 hold 1");
      step(32'h0000_0115, 3'b111, 1, 0, 0, 2, "R6 preempt to 2 b");

      // R7: expiry with no rival keeps owner, count restarts
      for (int i = 0; i < 5; i++) step(32'h0000_0115, 3'b100, 1, 0, 0, 2, "R7 sole owner");
      step(32'h0000_0115, 3'b101, 1, 0, 0, 0, "R7 restarted count expires");

      // R8: code 15 never preempts
      for (int i = 0; i < 6; i++) step(32'h0000_01F5, 3'b111, 1, 0, 0, 0, "R8 no preempt");

      // R5: priority levels m0=01 m1=00 m2=10
      step(32'h0002_11F4, 3'b110, 1, 0, 0, 2, "R5 high level");
      step(32'h0002_11F4, 3'b011, 1, 0, 0, 0, "R5 low over zero");
      step(32'h0002_11F4, 3'b010, 1, 0, 0, 1, "R5 zero level alone");
      // m0=10 m1=01 m2=10
      step(32'h0002_61F4, 3'b101, 1, 0, 0, 2, "R5 tie by pointer");
      step(32'h0002_61F4, 3'b011, 1, 0, 0, 0, "R5 level 2 over 1");
      step(32'h0002_61F4, 3'b110, 1, 0, 0, 2, "R5 level 2 over 1 b");

      // R9: quantum counted in transfers
      step(32'h0000_011D, 3'b111, 0, 0, 0, 2, "R9 no beat");
      step(32'h0000_011D, 3'b111, 0, 0, 0, 2, "R9 no beat 2");
      step(32'h0000_011D, 3'b111, 1, 0, 0, 2, "R9 beat 1");
      step(32'h0000_011D, 3'b111, 0, 0, 0, 2, "R9 idle");
      step(32'h0000_011D, 3'b111, 1, 0, 0, 0, "R9 beat 2 expires");

      // R10: protected burst (threshold 8, length 4) held past expiry
      step(32'h0000_0105, 3'b111, 1, 4, 0, 0, "R10 burst beat1");
      step(32'h0000_0105, 3'b111, 0, 4, 0, 0, "R11 no boundary");
      step(32'h0000_0105, 3'b111, 1, 4, 0, 0, "R10 burst beat");
      step(32'h0000_0105, 3'b111, 1, 4, 1, 1, "R10 final beat releases");
      step(32'h0000_0105, 3'b111, 1, 16, 0, 2, "R10 long burst broken");
      step(32'h0000_0101, 3'b111, 1, 4, 0, 0, "R10 break all");
      step(32'h0000_0107, 3'b111, 1, 16, 0, 0, "R10 never break");
      step(32'h0000_0107, 3'b111, 1, 16, 1, 1, "R10 never break final");
      step(32'h0000_0105, 3'b111, 0, 0, 0, 1, "R11 expired no beat");
      step(32'h0000_0105, 3'b111, 0, 0, 0, 1, "R11 expired no beat 2");
      step(32'h0000_0105, 3'b111, 1, 0, 0, 2, "R11 beat boundary");
      step(32'h0000_0103, 3'b111, 1, 8, 0, 0, "R10 threshold 4 breaks 8");

      // R13: reserved bits set
      step(32'hFFFC_0D05, 3'b111, 1, 0, 0, 1, "R13 reserved 1");
      step(32'hFFFC_0D05, 3'b111, 1, 0, 0, 2, "R13 reserved 2");
      step(32'hFFFC_0D05, 3'b111, 1, 0, 0, 0, "R13 reserved 3");
      step(32'hFFFC_0D05, 3'b000, 0, 0, 0, 1, "R13 park field");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule